// File: doc/BRIEF.md
# Byte-wide arithmetic and logic unit with processor status flags

This block is the arithmetic and logic stage of a small 8-bit accumulator processor. A sequencer presents an operation code, the accumulator, an operand byte (immediate or fetched from memory), the value of one index register, and the current carry, overflow, negative and zero flags. The unit computes the result together with new flag values and a write-enable for the result and for each flag. All outputs are registered, so they appear one clock after the inputs are presented.

Flags follow the processor's conventions. Subtraction is carried out as addition of the inverted operand, so carry set means "no borrow". Compares reuse the subtract path with carry forced in and leave overflow alone. Bit test takes negative and overflow straight from the operand. Three combined immediate operations AND the accumulator with the operand and then copy the top bit into carry, shift right, or rotate right. Only binary arithmetic is supported. The data width `W` is a parameter with a default of 8 and must be at least 4.

When a flag's write-enable is low, that flag output carries the incoming flag value unchanged. When the result write-enable is low, the result output is zero.

Top module: `byte_alu`

## Requirements
- R1: Operation code 0 (add) produces acc + opnd + c_i. Carry is set when the unsized sum exceeds 2^W-1. Overflow is set when both acc and opnd differ in their top bit from the result. The result, C, Z, N and V are written.
- R2: Operation code 1 (subtract) produces acc - opnd - (1 - c_i). Carry is set when the true difference is non-negative. Overflow is set when the signed difference falls outside the signed W-bit range. The result, C, Z, N and V are written.
- R3: Operation codes 2 and 3 compare the register (acc for code 2, idx_i for code 3) with opnd. C is set when the register is greater than or equal to opnd, Z is set when they are equal, and N takes the top bit of the W-bit difference. Neither the result nor V is written.
- R4: Operation codes 4, 5 and 6 return acc AND, OR and XOR opnd respectively, and write the result, Z and N.
- R5: For every operation that writes the result, Z is set exactly when the result is zero, and N equals the result's top bit.
- R6: Operation codes 12 and 13 return opnd + 1 and opnd - 1, wrapping modulo 2^W. They write the result, Z and N, and never write C.
- R7: Operation code 7 (bit test) sets Z when (acc AND opnd) is zero, copies opnd bit W-1 to N and opnd bit W-2 to V. It writes neither the result nor C.
- R8: Operation codes 8 to 11 act on opnd. Code 8 shifts left, code 9 shifts right, code 10 rotates left and code 11 rotates right. Bits shifted in are 0 for shifts and the old carry for rotates, and the bit shifted out goes to C. The result, C, Z and N are written.
- R9: Operation code 14 returns acc AND opnd and copies the result's top bit into C, writing the result, C, Z and N.
- R10: Operation code 15 shifts (acc AND opnd) right by one, moving its bit 0 into C, and writes the result, C, Z and N.
- R11: Operation code 16 rotates (acc AND opnd) right through the old carry. C then takes result bit W-2, and V takes result bit W-2 XOR bit W-3. The result, C, Z, N and V are written.
- R12: Operation codes 17 to 31 write nothing. For any operation, a flag output whose write-enable is low equals the incoming flag, and the result output is zero when res_we_o is low.
- R13: Outputs are registered and show the outcome of the inputs sampled at the previous rising clock edge. While rst is high, every output is cleared to zero at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| acc_i | input | W | Accumulator value |
| opnd_i | input | W | Operand (immediate or memory byte) |
| idx_i | input | W | Index register value for compare code 3 |
| c_i | input | 1 | Current carry flag |
| v_i | input | 1 | Current overflow flag |
| n_i | input | 1 | Current negative flag |
| z_i | input | 1 | Current zero flag |
| res_o | output | W | Result value, zero when not written |
| res_we_o | output | 1 | Result write-enable |
| c_o | output | 1 | New carry flag |
| z_o | output | 1 | New zero flag |
| n_o | output | 1 | New negative flag |
| v_o | output | 1 | New overflow flag |
| c_we_o | output | 1 | Carry write-enable |
| z_we_o | output | 1 | Zero write-enable |
| n_we_o | output | 1 | Negative write-enable |
| v_we_o | output | 1 | Overflow write-enable |

## Verification
The bench builds two copies of the unit: one at the default width of 8 and one with `W` set to 4. For the 4-bit copy it sweeps all 32 operation codes against every accumulator value, every operand value and both carry inputs. This covers every carry, overflow and zero boundary, every signed wrap, and every undefined operation code. The 8-bit copy runs the directed flag cases for the processor's full byte width and a pseudo-random sweep over all operations. The bench computes its expected outcomes with plain integer and signed arithmetic, not with a bit-level copy of the design.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD    = 5'd0,
    OP_SUB    = 5'd1,
    OP_CMPA   = 5'd2,
    OP_CMPR   = 5'd3,
    OP_AND    = 5'd4,
    OP_OR     = 5'd5,
    OP_XOR    = 5'd6,
    OP_BIT    = 5'd7,
    OP_SHL    = 5'd8,
    OP_SHR    = 5'd9,
    OP_ROL    = 5'd10,
    OP_ROR    = 5'd11,
    OP_INC    = 5'd12,
    OP_DEC    = 5'd13,
    OP_ANDC   = 5'd14,
    OP_ANDSHR = 5'd15,
    OP_ANDROR = 5'd16
  } op_e;

  typedef enum logic [1:0] {U_NONE, U_ADD, U_LOGIC, U_SHIFT} unit_e;
  typedef enum logic [1:0] {L_AND, L_OR, L_XOR} logic_fn_e;
  typedef enum logic [1:0] {A_ACC, A_IDX, A_OPND} asel_e;
  typedef enum logic [1:0] {CI_FLAG, CI_ONE, CI_ZERO} cin_e;
  typedef enum logic [1:0] {CS_ADD, CS_SHIFT, CS_MSB, CS_ROT6} csrc_e;
  typedef enum logic [1:0] {VS_ADD, VS_BIT, VS_ROT} vsrc_e;

  typedef struct packed {
    unit_e     unit;
    logic_fn_e lfn;
    asel_e     asel;
    logic      b_zero;
    logic      sub;
    cin_e      cin;
    logic      sh_left;
    logic      sh_rot;
    logic      sh_pre_and;
    csrc_e     csrc;
    vsrc_e     vsrc;
    logic      z_from_and;
    logic      n_from_opnd;
    logic      res_we;
    logic      c_we;
    logic      z_we;
    logic      n_we;
    logic      v_we;
  } ctrl_t;

endpackage

// File: rtl/byte_alu_decode.sv
module byte_alu_decode
  import byte_alu_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output ctrl_t           ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.unit = U_NONE;
    ctrl.lfn  = L_AND;
    ctrl.asel = A_ACC;
    ctrl.cin  = CI_FLAG;
    ctrl.csrc = CS_ADD;
    ctrl.vsrc = VS_ADD;
    case (op)
      OP_ADD, OP_SUB: begin
        ctrl.unit   = U_ADD;
        ctrl.sub    = (op == OP_SUB);
        ctrl.res_we = 1'b1;
        ctrl.c_we   = 1'b1;
        ctrl.z_we   = 1'b1;
        ctrl.n_we   = 1'b1;
        ctrl.v_we   = 1'b1;
      end
      OP_CMPA, OP_CMPR: begin
        ctrl.unit = U_ADD;
        ctrl.asel = (op == OP_CMPR) ? A_IDX : A_ACC;
        ctrl.sub  = 1'b1;
        ctrl.cin  = CI_ONE;
        ctrl.c_we = 1'b1;
        ctrl.z_we = 1'b1;
        ctrl.n_we = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_ANDC: begin
        ctrl.unit   = U_LOGIC;
        ctrl.lfn    = (op == OP_OR)  ? L_OR :
                      (op == OP_XOR) ? L_XOR : L_AND;
        ctrl.res_we = 1'b1;
        ctrl.z_we   = 1'b1;
        ctrl.n_we   = 1'b1;
        if (op == OP_ANDC) begin
          ctrl.csrc = CS_MSB;
          ctrl.c_we = 1'b1;
        end
      end
      OP_BIT: begin
        ctrl.z_from_and  = 1'b1;
        ctrl.n_from_opnd = 1'b1;
        ctrl.vsrc        = VS_BIT;
        ctrl.z_we        = 1'b1;
        ctrl.n_we        = 1'b1;
        ctrl.v_we        = 1'b1;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR, OP_ANDSHR, OP_ANDROR: begin
        ctrl.unit       = U_SHIFT;
        ctrl.sh_left    = (op == OP_SHL) || (op == OP_ROL);
        ctrl.sh_rot     = (op == OP_ROL) || (op == OP_ROR) || (op == OP_ANDROR);
        ctrl.sh_pre_and = (op == OP_ANDSHR) || (op == OP_ANDROR);
        ctrl.csrc       = (op == OP_ANDROR) ? CS_ROT6 : CS_SHIFT;
        ctrl.res_we     = 1'b1;
        ctrl.c_we       = 1'b1;
        ctrl.z_we       = 1'b1;
        ctrl.n_we       = 1'b1;
        if (op == OP_ANDROR) begin
          ctrl.vsrc = VS_ROT;
          ctrl.v_we = 1'b1;
        end
      end
      OP_INC, OP_DEC: begin
        ctrl.unit   = U_ADD;
        ctrl.asel   = A_OPND;
        ctrl.b_zero = 1'b1;
        ctrl.sub    = (op == OP_DEC);
        ctrl.cin    = (op == OP_DEC) ? CI_ZERO : CI_ONE;
        ctrl.res_we = 1'b1;
        ctrl.z_we   = 1'b1;
        ctrl.n_we   = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/byte_alu_adder.sv
module byte_alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);

  logic [W-1:0] b_eff;
  logic [W:0]   full;

  always_comb begin
    b_eff = sub ? ~b : b;
    full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    sum   = full[W-1:0];
    cout  = full[W];
    // signed overflow: both addends agree in sign, sum does not
    ovf   = (a[W-1] ^ sum[W-1]) & (b_eff[W-1] ^ sum[W-1]);
  end

endmodule

// File: rtl/byte_alu_shifter.sv
module byte_alu_shifter #(
  parameter int W = 8
) (
  input  logic [W-1:0] val,
  input  logic         cin,
  input  logic         left,
  input  logic         rot,
  output logic [W-1:0] out,
  output logic         cout
);

  logic fill;
  assign fill = rot & cin;
  assign cout = left ? val[W-1] : val[0];

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign out[i] = left ? fill : val[i+1];
    end else if (i == W-1) begin : g_hi
      assign out[i] = left ? val[i-1] : fill;
    end else begin : g_mid
      assign out[i] = left ? val[i-1] : val[i+1];
    end
  end

endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    acc_i,
  input  logic [W-1:0]    opnd_i,
  input  logic [W-1:0]    idx_i,
  input  logic            c_i,
  input  logic            v_i,
  input  logic            n_i,
  input  logic            z_i,
  output logic [W-1:0]    res_o,
  output logic            res_we_o,
  output logic            c_o,
  output logic            z_o,
  output logic            n_o,
  output logic            v_o,
  output logic            c_we_o,
  output logic            z_we_o,
  output logic            n_we_o,
  output logic            v_we_o
);

  localparam int MSB = W - 1;
  localparam int B6  = W - 2;
  localparam int B5  = W - 3;

  ctrl_t ctrl;

  byte_alu_decode u_dec (
    .op   (op_i),
    .ctrl (ctrl)
  );

  // adder path: add, subtract, compare, increment, decrement
  logic [W-1:0] add_a, add_b, add_sum;
  logic         add_cin, add_cout, add_ovf;

  always_comb begin
    case (ctrl.asel)
      A_IDX:   add_a = idx_i;
      A_OPND:  add_a = opnd_i;
      default: add_a = acc_i;
    endcase
    add_b = ctrl.b_zero ? '0 : opnd_i;
    case (ctrl.cin)
      CI_ONE:  add_cin = 1'b1;
      CI_ZERO: add_cin = 1'b0;
      default: add_cin = c_i;
    endcase
  end

  byte_alu_adder #(.W(W)) u_add (
    .a    (add_a),
    .b    (add_b),
    .sub  (ctrl.sub),
    .cin  (add_cin),
    .sum  (add_sum),
    .cout (add_cout),
    .ovf  (add_ovf)
  );

  // bitwise path
  logic [W-1:0] and_v, log_v;
  assign and_v = acc_i & opnd_i;

  always_comb begin
    case (ctrl.lfn)
      L_OR:    log_v = acc_i | opnd_i;
      L_XOR:   log_v = acc_i ^ opnd_i;
      default: log_v = and_v;
    endcase
  end

  // shift path, optionally fed by the AND of acc and operand
  logic [W-1:0] sh_in, sh_out;
  logic         sh_cout;
  assign sh_in = ctrl.sh_pre_and ? and_v : opnd_i;

  byte_alu_shifter #(.W(W)) u_sh (
    .val  (sh_in),
    .cin  (c_i),
    .left (ctrl.sh_left),
    .rot  (ctrl.sh_rot),
    .out  (sh_out),
    .cout (sh_cout)
  );

  // select value and derive flags
  logic [W-1:0] calc;
  logic         c_new, v_new, z_new, n_new;

  always_comb begin
    case (ctrl.unit)
      U_ADD:   calc = add_sum;
      U_LOGIC: calc = log_v;
      U_SHIFT: calc = sh_out;
      default: calc = '0;
    endcase
    case (ctrl.csrc)
      CS_SHIFT: c_new = sh_cout;
      CS_MSB:   c_new = calc[MSB];
      CS_ROT6:  c_new = calc[B6];
      default:  c_new = add_cout;
    endcase
    case (ctrl.vsrc)
      VS_BIT:  v_new = opnd_i[B6];
      VS_ROT:  v_new = calc[B6] ^ calc[B5];
      default: v_new = add_ovf;
    endcase
    z_new = ctrl.z_from_and  ? (and_v == '0) : (calc == '0);
    n_new = ctrl.n_from_opnd ? opnd_i[MSB]   : calc[MSB];
  end

  // output register stage
  always_ff @(posedge clk) begin
    if (rst) begin
      res_o    <= '0;
      res_we_o <= 1'b0;
      c_o      <= 1'b0;
      z_o      <= 1'b0;
      n_o      <= 1'b0;
      v_o      <= 1'b0;
      c_we_o   <= 1'b0;
      z_we_o   <= 1'b0;
      n_we_o   <= 1'b0;
      v_we_o   <= 1'b0;
    end else begin
      res_o    <= ctrl.res_we ? calc : '0;
      res_we_o <= ctrl.res_we;
      c_o      <= ctrl.c_we ? c_new : c_i;
      z_o      <= ctrl.z_we ? z_new : z_i;
      n_o      <= ctrl.n_we ? n_new : n_i;
      v_o      <= ctrl.v_we ? v_new : v_i;
      c_we_o   <= ctrl.c_we;
      z_we_o   <= ctrl.z_we;
      n_we_o   <= ctrl.n_we;
      v_we_o   <= ctrl.v_we;
    end
  end

endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [4:0]   op_i,
  input logic [W-1:0] acc_i,
  input logic [W-1:0] opnd_i,
  input logic         c_i,
  input logic [W-1:0] res_o,
  input logic         res_we_o,
  input logic         c_we_o,
  input logic         v_we_o,
  input logic         c_o,
  input logic         z_o,
  input logic         n_o,
  input logic         v_o
);

  logic [W:0] wide_sum;
  assign wide_sum = {1'b0, acc_i} + {1'b0, opnd_i} + {{W{1'b0}}, c_i};

  // R1: carry after add reflects the unsized sum
  p_add_carry_r1: assert property (@(posedge clk) disable iff (rst)
    (op_i == 5'd0) |=> (c_we_o && c_o == $past(wide_sum[W])));

  // R3: compares leave result and overflow alone
  p_cmp_no_v_r3: assert property (@(posedge clk) disable iff (rst)
    (op_i == 5'd2 || op_i == 5'd3) |=> (!v_we_o && !res_we_o));

  // R5: zero and negative follow a written result
  p_z_follows_res_r5: assert property (@(posedge clk) disable iff (rst)
    res_we_o |-> (z_o == (res_o == '0)));
  p_n_follows_res_r5: assert property (@(posedge clk) disable iff (rst)
    res_we_o |-> (n_o == res_o[W-1]));

  // R6: increment and decrement keep carry
  p_incdec_keep_c_r6: assert property (@(posedge clk) disable iff (rst)
    (op_i == 5'd12 || op_i == 5'd13) |=> (!c_we_o && c_o == $past(c_i)));

  // R7: bit test flag sources
  p_bit_flags_r7: assert property (@(posedge clk) disable iff (rst)
    (op_i == 5'd7) |=> (!res_we_o && n_o == $past(opnd_i[W-1])
                        && v_o == $past(opnd_i[W-2])));

  // R12: undefined codes write nothing
  p_undef_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (op_i > 5'd16) |=> (!res_we_o && !c_we_o && !v_we_o && c_o == $past(c_i)));

endmodule

bind byte_alu byte_alu_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_i     (op_i),
  .acc_i    (acc_i),
  .opnd_i   (opnd_i),
  .c_i      (c_i),
  .res_o    (res_o),
  .res_we_o (res_we_o),
  .c_we_o   (c_we_o),
  .v_we_o   (v_we_o),
  .c_o      (c_o),
  .z_o      (z_o),
  .n_o      (n_o),
  .v_o      (v_o)
);

// File: tb/sim_byte_alu.sv
`timescale 1ns/1ps
module sim_byte_alu;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;

  logic [4:0] op;
  logic [7:0] a8, m8, r8;
  logic [3:0] a4, m4, r4;
  logic       ci, vi, ni, zi;

  logic [7:0] res8;
  logic [3:0] res4;
  logic       rwe8, c8, z8, n8, v8, cw8, zw8, nw8, vw8;
  logic       rwe4, c4, z4, n4, v4, cw4, zw4, nw4, vw4;

  byte_alu #(.W(8)) u0 (
    .clk(clk), .rst(rst), .op_i(op), .acc_i(a8), .opnd_i(m8), .idx_i(r8),
    .c_i(ci), .v_i(vi), .n_i(ni), .z_i(zi),
    .res_o(res8), .res_we_o(rwe8), .c_o(c8), .z_o(z8), .n_o(n8), .v_o(v8),
    .c_we_o(cw8), .z_we_o(zw8), .n_we_o(nw8), .v_we_o(vw8)
  );

  byte_alu #(.W(4)) u1 (
    .clk(clk), .rst(rst), .op_i(op), .acc_i(a4), .opnd_i(m4), .idx_i(r4),
    .c_i(ci), .v_i(vi), .n_i(ni), .z_i(zi),
    .res_o(res4), .res_we_o(rwe4), .c_o(c4), .z_o(z4), .n_o(n4), .v_o(v4),
    .c_we_o(cw4), .z_we_o(zw4), .n_we_o(nw4), .v_we_o(vw4)
  );

  function automatic int sgn(int x, int w);
    return ((x >> (w - 1)) & 1) ? x - (1 << w) : x;
  endfunction

  // packing: {res[7:0], res_we, c_we, z_we, n_we, v_we, c, z, n, v}
  function automatic logic [16:0] model(int w, int opc, int a, int m, int r,
                                        bit cin, bit vin, bit nin, bit zin);
    int  mask = (1 << w) - 1;
    int  msb  = 1 << (w - 1);
    int  calc = 0;
    int  t, d;
    bit  rwe = 0, cwe = 0, zwe = 0, nwe = 0, vwe = 0, zn = 0;
    bit  c = cin, z = zin, n = nin, v = vin;
    logic [7:0] rv;
    case (opc)
      0: begin
        t = a + m + (cin ? 1 : 0);
        calc = t & mask; c = (t > mask);
        d = sgn(a, w) + sgn(m, w) + (cin ? 1 : 0);
        v = (d < -msb) || (d > msb - 1);
        rwe = 1; cwe = 1; vwe = 1; zn = 1;
      end
      1: begin
        t = a - m - (cin ? 0 : 1);
        calc = t & mask; c = (t >= 0);
        d = sgn(a, w) - sgn(m, w) - (cin ? 0 : 1);
        v = (d < -msb) || (d > msb - 1);
        rwe = 1; cwe = 1; vwe = 1; zn = 1;
      end
      2, 3: begin
        t = (opc == 2) ? a : r;
        c = (t >= m); calc = (t - m) & mask;
        cwe = 1; zn = 1;
      end
      4: begin calc = a & m; rwe = 1; zn = 1; end
      5: begin calc = a | m; rwe = 1; zn = 1; end
      6: begin calc = a ^ m; rwe = 1; zn = 1; end
      7: begin
        z = ((a & m) == 0); n = ((m & msb) != 0); v = ((m & (msb >> 1)) != 0);
        zwe = 1; nwe = 1; vwe = 1;
      end
      8:  begin c = ((m & msb) != 0); calc = (m << 1) & mask; rwe = 1; cwe = 1; zn = 1; end
      9:  begin c = ((m & 1) != 0); calc = m >> 1; rwe = 1; cwe = 1; zn = 1; end
      10: begin c = ((m & msb) != 0); calc = ((m << 1) | (cin ? 1 : 0)) & mask;
                rwe = 1; cwe = 1; zn = 1; end
      11: begin c = ((m & 1) != 0); calc = (m >> 1) | (cin ? msb : 0);
                rwe = 1; cwe = 1; zn = 1; end
      12: begin calc = (m + 1) & mask; rwe = 1; zn = 1; end
      13: begin calc = (m - 1) & mask; rwe = 1; zn = 1; end
      14: begin calc = a & m; c = ((calc & msb) != 0); rwe = 1; cwe = 1; zn = 1; end
      15: begin t = a & m; c = ((t & 1) != 0); calc = t >> 1; rwe = 1; cwe = 1; zn = 1; end
      16: begin
        t = a & m; calc = (t >> 1) | (cin ? msb : 0);
        c = (((calc >> (w - 2)) & 1) != 0);
        v = ((((calc >> (w - 2)) ^ (calc >> (w - 3))) & 1) != 0);
        rwe = 1; cwe = 1; vwe = 1; zn = 1;
      end
      default: ;
    endcase
    if (zn) begin
      z = (calc == 0); n = ((calc & msb) != 0); zwe = 1; nwe = 1;
    end
    rv = rwe ? calc[7:0] : 8'h00;
    return {rv, rwe, cwe, zwe, nwe, vwe, c, z, n, v};
  endfunction

  function automatic string req_of(int opc);
    case (opc)
      0: return "R1";
      1: return "R2";
      2, 3: return "R3";
      4, 5, 6: return "R4";
      7: return "R7";
      8, 9, 10, 11: return "R8";
      12, 13: return "R6";
      14: return "R9";
      15: return "R10";
      16: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [16:0] got8();
    return {res8, rwe8, cw8, zw8, nw8, vw8, c8, z8, n8, v8};
  endfunction
  function automatic logic [16:0] got4();
    return {4'h0, res4, rwe4, cw4, zw4, nw4, vw4, c4, z4, n4, v4};
  endfunction

  task automatic check(string req, logic [16:0] got, logic [16:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s op=%0d got=%05h exp=%05h", req, op, got, exp);
    end
  endtask

  // drive on the falling edge, sample one rising edge later (R13)
  task automatic apply(int opc, logic [7:0] a, logic [7:0] m, logic [7:0] r,
                       logic [3:0] an, logic [3:0] mn, logic [3:0] rn,
                       bit cin, bit vin, bit nin, bit zin);
    @(negedge clk);
    op = opc[4:0]; a8 = a; m8 = m; r8 = r; a4 = an; m4 = mn; r4 = rn;
    ci = cin; vi = vin; ni = nin; zi = zin;
    @(posedge clk);
    #1;
    check(req_of(opc), got8(), model(8, opc, a, m, r, cin, vin, nin, zin));
    check(req_of(opc), got4(), model(4, opc, an, mn, rn, cin, vin, nin, zin));
  endtask

  task automatic lit(string req, bit cond, int gotv, int expv);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s literal got=%0h exp=%0h", req, gotv, expv);
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    op = 5'd0; a8 = 8'h5A; m8 = 8'hA5; r8 = 8'h33; a4 = 4'h5; m4 = 4'hA; r4 = 4'h3;
    ci = 1'b1; vi = 1'b1; ni = 1'b1; zi = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R13: reset clears every output even with live inputs
    check("R13", got8(), 17'h0);
    check("R13", got4(), 17'h0);
    @(negedge clk);
    rst = 1'b0;

    // directed byte-wide cases
    apply(0, 8'h7F, 8'h01, 0, 0, 0, 0, 0, 0, 0, 0);
    lit("R1", res8 == 8'h80 && v8 && n8 && !c8, res8, 8'h80);
    apply(0, 8'hFF, 8'h01, 0, 0, 0, 0, 0, 0, 0, 0);
    lit("R1", res8 == 8'h00 && c8 && z8, res8, 0);
    apply(1, 8'h80, 8'h01, 0, 0, 0, 0, 1, 0, 1, 0);
    lit("R2", res8 == 8'h7F && v8 && !n8 && c8, res8, 8'h7F);
    apply(2, 8'h50, 8'h30, 0, 0, 0, 0, 0, 1, 0, 0);
    lit("R3", c8 && !z8 && !rwe8 && v8, c8, 1);
    apply(2, 8'h50, 8'h50, 0, 0, 0, 0, 0, 0, 0, 0);
    lit("R3", c8 && z8, z8, 1);
    apply(3, 8'h00, 8'h70, 8'h50, 0, 0, 0, 1, 0, 0, 0);
    lit("R3", !c8 && !z8, c8, 0);
    apply(12, 0, 8'hFF, 0, 0, 0, 0, 1, 0, 0, 0);
    lit("R6", res8 == 8'h00 && z8 && c8 && !cw8, res8, 0);
    apply(13, 0, 8'h01, 0, 0, 0, 0, 0, 0, 0, 0);
    lit("R6", res8 == 8'h00 && z8 && !c8, res8, 0);
    apply(11, 0, 8'h01, 0, 0, 0, 0, 1, 0, 0, 0);
    lit("R8", res8 == 8'h80 && c8, res8, 8'h80);
    apply(7, 8'h00, 8'hC0, 0, 0, 0, 0, 0, 0, 0, 0);
    lit("R7", z8 && n8 && v8 && !rwe8, {z8, n8, v8}, 7);
    apply(14, 8'h80, 8'hFF, 0, 0, 0, 0, 0, 0, 0, 0);
    lit("R9", c8, c8, 1);
    apply(14, 8'h7F, 8'hFF, 0, 0, 0, 0, 1, 0, 0, 0);
    lit("R9", !c8, c8, 0);
    apply(15, 8'hFF, 8'h55, 0, 0, 0, 0, 0, 0, 0, 0);
    lit("R10", res8 == 8'h2A && c8, res8, 8'h2A);
    apply(16, 8'hFF, 8'h55, 0, 0, 0, 0, 1, 0, 0, 0);
    lit("R11", res8 == 8'hAA && !c8 && v8, res8, 8'hAA);
    apply(20, 8'h12, 8'h34, 0, 0, 0, 0, 1, 0, 1, 1);
    lit("R12", !rwe8 && res8 == 0 && c8 && !v8 && n8 && z8, res8, 0);

    // exhaustive sweep of the 4-bit copy, all codes (R5 on every result op)
    for (int o = 0; o < 32; o++)
      for (int a = 0; a < 16; a++)
        for (int m = 0; m < 16; m++)
          for (int c = 0; c < 2; c++) begin
            logic [3:0] an, mn, rn;
            an = a[3:0]; mn = m[3:0]; rn = an ^ ~mn;
            apply(o, {an, an}, {mn, mn ^ an}, {rn, mn},
                  an, mn, rn, c[0], c[0] ^ an[0], mn[0], an[1]);
          end

    // pseudo-random sweep for the byte-wide copy
    seed = 32'h1234;
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] s;
      seed = seed * 1103515245 + 12345;
      s = seed;
      apply(i % 17, s[23:16], s[15:8], s[31:24], s[19:16], s[11:8], s[27:24],
            s[7], s[6], s[5], s[4]);
    end

    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R13", got8(), 17'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule